// File: doc/BRIEF.md
# Command Prefetch and Dispatch Front End

This block reads a command stream out of memory and hands each command, one at a time and in stream order, to the execution unit that owns it. A prefetcher keeps read requests flowing into a small queue so that decode is not held up by memory latency. Read requests carry one extra address bit that selects local memory (0) or system memory reached over the host link (1).

Each 32-bit command word holds an opcode in bits [31:28]. The decoder sends draw and compute commands to a shared command bus, where a per-unit valid/ready pair names the unit. It resolves flow-control commands itself. Jump, call and return commands move the prefetch pointer and throw away anything already fetched past the branch. A call saves its return point on a small hardware stack. Software starts the block with a one-cycle start pulse that carries the first address.

Top module: `cmd_front_end`

## Requirements
- R1: Fetching runs ahead of decode. While decode is stalled, requests keep being issued until the queued words plus the live outstanding reads equal FIFO_DEPTH (8). Requests then stop, and the queue never overflows.
- R2: `memReqSys` carries the space bit of the current fetch pointer. A jump or call target takes its space bit from command bit 16 and its word address from bits [15:0]. A return restores both.
- R3: Opcodes 1, 2, 3 and 4 (2D, 3D, compute, sync) go to unit 0, 1, 2 and 3 respectively. `unitCmd` carries the whole word, and at most one `unitValid` bit is high at a time.
- R4: Commands issue strictly in stream order. While the addressed unit holds ready low, the command stays on the bus unchanged and no later command reaches any unit.
- R5: Jump (opcode 8) restarts fetching at its target. Queued words and outstanding read responses from beyond the branch are discarded and never issued.
- R6: Call (opcode 9) pushes the address of the word after it onto a 4-entry return stack and then jumps. Return (opcode 10) pops that entry and continues from it. Calls nest four deep.
- R7: A call made with the stack full still jumps but pushes nothing. A return made with the stack empty falls through to the next word. Either case sets `stackErr`, which then stays high until the next start.
- R8: Opcode 0 and the reserved opcodes 5, 6, 7, 11, 12, 13 and 14 are consumed without reaching any unit.
- R9: After reset, and after a halt command (opcode 15), no read request is issued and no command is presented until the next start.
- R10: A start pulse clears the return stack and `stackErr`, discards all fetched state, and begins fetching at `startAddr` in the space chosen by `startSys`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a stream |
| startAddr | input | 16 | First word address of the stream |
| startSys | input | 1 | Space of the first word: 0 local, 1 system |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 16 | Word address of the request |
| memReqSys | output | 1 | Space select: 0 local, 1 system |
| memRspValid | input | 1 | Read data valid; responses return in request order |
| memRspData | input | 32 | Read data |
| unitValid | output | 4 | Command valid, one bit per unit (2D, 3D, compute, sync) |
| unitReady | input | 4 | Unit ready, one bit per unit |
| unitCmd | output | 32 | Command word shared by all units |
| stackErr | output | 1 | Sticky return-stack overflow or underflow flag |

## Verification
The bench stalls the 3D unit right after start and checks the prefetch count and the request line. A design that ignored the credit limit would request past nine words and overflow its queue. A call into system memory, whose local copy at the same address holds a poison word, exposes a lost space bit. Poison words also sit just past every branch, so a design that failed to flush stale queue entries or late responses would issue them. Nested calls four deep and then five deep, plus a return on an empty stack, separate correct stack depth handling from an off-by-one or a missing error flag.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam int OP_W      = 4;
  localparam int NUM_UNITS = 4;

  localparam logic [OP_W-1:0] OP_NOP     = 4'd0;
  localparam logic [OP_W-1:0] OP_DRAW2D  = 4'd1;
  localparam logic [OP_W-1:0] OP_DRAW3D  = 4'd2;
  localparam logic [OP_W-1:0] OP_COMPUTE = 4'd3;
  localparam logic [OP_W-1:0] OP_SYNC    = 4'd4;
  localparam logic [OP_W-1:0] OP_JUMP    = 4'd8;
  localparam logic [OP_W-1:0] OP_CALL    = 4'd9;
  localparam logic [OP_W-1:0] OP_RET     = 4'd10;
  localparam logic [OP_W-1:0] OP_HALT    = 4'd15;

  typedef struct packed {
    logic pop;        // retire the head word
    logic redirect;   // flush and restart fetch at target
    logic stop;       // flush and stop fetching
    logic pushRet;    // save return point
    logic popRet;     // drop top of return stack
    logic clearStack; // empty the return stack
  } ctrl_strobe_t;
endpackage

// File: rtl/cmdfe_datapath.sv
module cmdfe_datapath
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W:0]   tgtAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              memReqSys,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              headValid,
  output logic [DATA_W-1:0] headData,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic [ADDR_W:0]   stackTop
);
  localparam int PTR_W    = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);
  localparam int PEND_MAX = 2 * FIFO_DEPTH;
  localparam int PEND_W   = $clog2(PEND_MAX + 1);
  localparam int SP_W     = $clog2(STACK_DEPTH + 1);
  localparam int SIDX_W   = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [DATA_W-1:0] fifoData [FIFO_DEPTH];
  logic [ADDR_W:0]   fifoAddr [FIFO_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  fifoCnt;
  logic              fetchOn;
  logic [ADDR_W:0]   fetchPtr, rspPtr;
  logic [PEND_W-1:0] pendCnt, dropCnt, pendNext, liveCnt;
  logic [PEND_W:0]   occ;
  logic              reqFire, wrEn, popEn, flush;
  logic [ADDR_W:0]   stackMem [STACK_DEPTH];
  logic [SP_W-1:0]   sp;
  logic [ADDR_W:0]   headAddr, retAddr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // ---------------- fetch credit ----------------
  assign liveCnt     = pendCnt - dropCnt;
  assign occ         = (PEND_W+1)'(fifoCnt) + (PEND_W+1)'(liveCnt);
  assign memReqValid = fetchOn && (occ < (PEND_W+1)'(FIFO_DEPTH))
                       && (pendCnt < PEND_W'(PEND_MAX));
  assign memReqAddr  = fetchPtr[ADDR_W-1:0];
  assign memReqSys   = fetchPtr[ADDR_W];
  assign reqFire     = memReqValid && memReqReady;
  assign flush       = strobe.redirect || strobe.stop;
  assign wrEn        = memRspValid && (dropCnt == '0) && !flush;
  assign popEn       = strobe.pop && headValid && !flush;
  assign pendNext    = pendCnt + PEND_W'(reqFire) - PEND_W'(memRspValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchOn  <= 1'b0;
      fetchPtr <= '0;
      rspPtr   <= '0;
      pendCnt  <= '0;
      dropCnt  <= '0;
    end else begin
      pendCnt <= pendNext;
      if (flush)
        dropCnt <= pendNext;             // everything in flight is stale
      else if (memRspValid && dropCnt != '0)
        dropCnt <= dropCnt - 1'b1;
      if (strobe.redirect) begin
        fetchOn  <= 1'b1;
        fetchPtr <= tgtAddr;
        rspPtr   <= tgtAddr;
      end else begin
        if (strobe.stop) fetchOn <= 1'b0;
        if (reqFire)
          fetchPtr <= {fetchPtr[ADDR_W], fetchPtr[ADDR_W-1:0] + 1'b1};
        if (wrEn)
          rspPtr <= {rspPtr[ADDR_W], rspPtr[ADDR_W-1:0] + 1'b1};
      end
    end
  end

  // ---------------- prefetch queue ----------------
  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (popEn) rdPtr <= nextPtr(rdPtr);
      fifoCnt <= fifoCnt + CNT_W'(wrEn) - CNT_W'(popEn);
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      fifoData[wrPtr] <= memRspData;
      fifoAddr[wrPtr] <= rspPtr;
    end
  end

  assign headValid = (fifoCnt != '0);
  assign headData  = fifoData[rdPtr];
  assign headAddr  = fifoAddr[rdPtr];
  assign retAddr   = {headAddr[ADDR_W], headAddr[ADDR_W-1:0] + 1'b1};

  // ---------------- return stack ----------------
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign stackTop   = stackMem[SIDX_W'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearStack) begin
      sp <= '0;
    end else if (strobe.pushRet && !stackFull) begin
      stackMem[SIDX_W'(sp)] <= retAddr;
      sp <= sp + 1'b1;
    end else if (strobe.popRet && !stackEmpty) begin
      sp <= sp - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occ <= (PEND_W+1)'(FIFO_DEPTH)); // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.redirect |=> !headValid); // R5
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stop && !strobe.redirect) |=> !memReqValid); // R9
endmodule

// File: rtl/cmdfe_control.sv
module cmdfe_control
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic                 startSys,
  input  logic                 headValid,
  input  logic [DATA_W-1:0]    headData,
  input  logic                 stackFull,
  input  logic                 stackEmpty,
  input  logic [ADDR_W:0]      stackTop,
  input  logic [NUM_UNITS-1:0] unitReady,
  output ctrl_strobe_t         strobe,
  output logic [ADDR_W:0]      tgtAddr,
  output logic [NUM_UNITS-1:0] unitValid,
  output logic [DATA_W-1:0]    unitCmd,
  output logic                 stackErr
);
  localparam int UIDX_W = $clog2(NUM_UNITS);

  logic [OP_W-1:0]   op;
  logic [UIDX_W-1:0] unitIdx;
  logic              errSet;
  logic              stallNow;

  assign op      = headData[DATA_W-1 -: OP_W];
  assign unitIdx = UIDX_W'(op - 1'b1);   // 1..4 -> 0..3
  assign unitCmd = headData;

  always_comb begin
    strobe    = '0;
    tgtAddr   = '0;
    unitValid = '0;
    errSet    = 1'b0;
    if (start) begin
      strobe.redirect   = 1'b1;
      strobe.clearStack = 1'b1;
      tgtAddr           = {startSys, startAddr};
    end else if (headValid) begin
      case (op)
        OP_DRAW2D, OP_DRAW3D, OP_COMPUTE, OP_SYNC: begin
          unitValid  = NUM_UNITS'(1) << unitIdx;
          strobe.pop = unitReady[unitIdx];
        end
        OP_JUMP: begin
          strobe.redirect = 1'b1;
          tgtAddr         = headData[ADDR_W:0];
        end
        OP_CALL: begin
          strobe.redirect = 1'b1;
          strobe.pushRet  = 1'b1;
          tgtAddr         = headData[ADDR_W:0];
          errSet          = stackFull;
        end
        OP_RET: begin
          if (stackEmpty) begin
            errSet     = 1'b1;
            strobe.pop = 1'b1;
          end else begin
            strobe.redirect = 1'b1;
            strobe.popRet   = 1'b1;
            tgtAddr         = stackTop;
          end
        end
        OP_HALT: strobe.stop = 1'b1;
        default: strobe.pop  = 1'b1;     // no-op and reserved codes
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || start) stackErr <= 1'b0;
    else if (errSet)    stackErr <= 1'b1;
  end

  assign stallNow = (|unitValid) && !(|(unitValid & unitReady)) && !start;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(unitValid)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!start && $past(stallNow)) |-> (unitValid == $past(unitValid)
                                     && unitCmd == $past(unitCmd))); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stackErr && !start) |=> stackErr); // R7
endmodule

// File: rtl/cmd_front_end.sv
module cmd_front_end
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic                 startSys,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic                 memReqSys,
  input  logic                 memRspValid,
  input  logic [DATA_W-1:0]    memRspData,
  output logic [NUM_UNITS-1:0] unitValid,
  input  logic [NUM_UNITS-1:0] unitReady,
  output logic [DATA_W-1:0]    unitCmd,
  output logic                 stackErr
);
  ctrl_strobe_t      strobe;
  logic [ADDR_W:0]   tgtAddr, stackTop;
  logic              headValid, stackFull, stackEmpty;
  logic [DATA_W-1:0] headData;

  cmdfe_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH), .STACK_DEPTH(STACK_DEPTH)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtAddr(tgtAddr),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqSys(memReqSys),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .headValid(headValid), .headData(headData),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .stackTop(stackTop)
  );

  cmdfe_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_control (
    .clk(clk), .rstN(rstN), .start(start),
    .startAddr(startAddr), .startSys(startSys),
    .headValid(headValid), .headData(headData),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .stackTop(stackTop),
    .unitReady(unitReady), .strobe(strobe), .tgtAddr(tgtAddr),
    .unitValid(unitValid), .unitCmd(unitCmd), .stackErr(stackErr)
  );
endmodule

// File: tb/test_cmd_front_end.sv
module test_cmd_front_end;
  localparam int LAT = 5;
  localparam int NPROG = 27;
  localparam int NEXP = 5;

  // {sys, addr[6:0], word}
  localparam logic [39:0] PROG [NPROG] = '{
    {1'b0, 7'h00, 32'h1000_0001}, {1'b0, 7'h01, 32'h2000_0002},
    {1'b0, 7'h02, 32'h9001_0010}, {1'b0, 7'h03, 32'h3000_0003},
    {1'b0, 7'h04, 32'h8000_0020}, {1'b0, 7'h05, 32'h1000_0BAD},
    {1'b0, 7'h06, 32'h2000_0BAD}, {1'b0, 7'h10, 32'h1000_0BAD},
    {1'b1, 7'h10, 32'h1000_0011}, {1'b1, 7'h11, 32'hA000_0000},
    {1'b1, 7'h12, 32'h3000_0BAD}, {1'b1, 7'h03, 32'h2000_0BAD},
    {1'b0, 7'h20, 32'h5000_0000}, {1'b0, 7'h21, 32'h0000_0000},
    {1'b0, 7'h22, 32'h4000_0004}, {1'b0, 7'h23, 32'hA000_0000},
    {1'b0, 7'h24, 32'hF000_0000},
    {1'b0, 7'h40, 32'h9000_0050}, {1'b0, 7'h50, 32'h9000_0060},
    {1'b0, 7'h60, 32'h9000_0070}, {1'b0, 7'h70, 32'h9000_0030},
    {1'b0, 7'h30, 32'h4000_0030}, {1'b0, 7'h31, 32'hA000_0000},
    {1'b0, 7'h71, 32'hA000_0000}, {1'b0, 7'h61, 32'hA000_0000},
    {1'b0, 7'h51, 32'hA000_0000}, {1'b0, 7'h48, 32'h9000_0040}
  };
  // {unit, word} in issue order for the first stream
  localparam logic [33:0] EXPECT [NEXP] = '{
    {2'd0, 32'h1000_0001}, {2'd1, 32'h2000_0002}, {2'd0, 32'h1000_0011},
    {2'd2, 32'h3000_0003}, {2'd3, 32'h4000_0004}
  };

  logic clk = 1'b0;
  logic rstN, start, startSys, memReqReady, memRspValid, stackErr;
  logic memReqValid, memReqSys;
  logic [15:0] startAddr, memReqAddr;
  logic [31:0] memRspData, unitCmd;
  logic [3:0]  unitValid, unitReady;

  logic [31:0] locMem [128];
  logic [31:0] sysMem [128];
  logic        pv [LAT];
  logic [6:0]  pa [LAT];
  logic        ps [LAT];
  logic [31:0] logData [64];
  logic [1:0]  logUnit [64];
  int logN, reqCount, cyc;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  cmd_front_end i_cmd_front_end (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .startSys(startSys), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqSys(memReqSys), .memRspValid(memRspValid),
    .memRspData(memRspData), .unitValid(unitValid), .unitReady(unitReady),
    .unitCmd(unitCmd), .stackErr(stackErr)
  );

  // memory model: fixed latency, in-order, ready low one cycle in four
  assign memRspValid = pv[LAT-1];
  assign memRspData  = !pv[LAT-1] ? 32'h0 :
                       (ps[LAT-1] ? sysMem[pa[LAT-1]] : locMem[pa[LAT-1]]);

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    memReqReady <= ((cyc % 4) != 2);
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
      reqCount <= 0;
      logN <= 0;
    end else begin
      pv[0] <= memReqValid && memReqReady;
      pa[0] <= memReqAddr[6:0];
      ps[0] <= memReqSys;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; ps[i] <= ps[i-1];
      end
      if (memReqValid && memReqReady) reqCount <= reqCount + 1;
      for (int u = 0; u < 4; u++)
        if (unitValid[u] && unitReady[u]) begin
          logData[logN] <= unitCmd;
          logUnit[logN] <= 2'(u);
          logN <= logN + 1;
        end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic kick(input logic [15:0] a, input logic s);
    @(negedge clk);
    start = 1'b1; startAddr = a; startSys = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  int base, reqBase;

  initial begin
    cyc = 0;
    memReqReady = 1'b1;
    rstN = 1'b0; start = 1'b0; startAddr = '0; startSys = 1'b0;
    unitReady = 4'hF;
    for (int i = 0; i < 128; i++) begin
      locMem[i] = 32'hF000_0000;
      sysMem[i] = 32'hF000_0000;
    end
    for (int i = 0; i < NPROG; i++)
      if (PROG[i][39]) sysMem[PROG[i][38:32]] = PROG[i][31:0];
      else             locMem[PROG[i][38:32]] = PROG[i][31:0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "reset request", 32'(memReqValid), 32'd0);
    check("R9", "reset unitValid", 32'(unitValid), 32'd0);
    check("R10", "reset stackErr", 32'(stackErr), 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", "idle before start", 32'(memReqValid), 32'd0);

    // stream 1: stall the 3D unit first
    unitReady = 4'b1101;
    kick(16'h0000, 1'b0);
    repeat (40) @(negedge clk);
    check("R4", "issued while stalled", 32'(logN), 32'd1);
    check("R4", "stalled word held", unitCmd, 32'h2000_0002);
    check("R1", "prefetch count at full queue", 32'(reqCount), 32'd9);
    check("R1", "requests paused at full queue", 32'(memReqValid), 32'd0);
    unitReady = 4'hF;
    repeat (200) @(negedge clk);
    for (int i = 0; i < NEXP; i++) begin
      check("R3", "unit index", 32'(logUnit[i]), 32'(EXPECT[i][33:32]));
      check("R2_R5_R6", "issued word", logData[i], EXPECT[i][31:0]);
    end
    check("R5_R8", "issue count stream1", 32'(logN), 32'(NEXP));
    check("R7", "error after empty return", 32'(stackErr), 32'd1);
    check("R9", "quiet after halt", 32'(memReqValid), 32'd0);

    // stream 2: four nested calls
    base = logN; reqBase = reqCount;
    kick(16'h0040, 1'b0);
    check("R10", "start clears error", 32'(stackErr), 32'd0);
    repeat (300) @(negedge clk);
    check("R6", "nested 4 issue count", 32'(logN - base), 32'd1);
    check("R6", "nested 4 word", logData[base], 32'h4000_0030);
    check("R6", "nested 4 no error", 32'(stackErr), 32'd0);
    check("R10", "fetch restarted", 32'(reqCount > reqBase), 32'd1);

    // stream 3: five nested calls overflow
    base = logN;
    kick(16'h0048, 1'b0);
    repeat (300) @(negedge clk);
    check("R7", "overflow still jumps", 32'(logN - base), 32'd1);
    check("R7", "overflow word", logData[base], 32'h4000_0030);
    check("R7", "overflow error flag", 32'(stackErr), 32'd1);
    check("R9", "quiet after final halt", 32'(memReqValid), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule